// File: doc/BRIEF.md
# Return Compression Call Stack Tracker

This block follows the near CALL and RET events retired by one logical processor. For every RET it decides whether the trace can report that return as one "taken" conditional-branch bit, or whether it must send a full target-address packet carrying the return destination. To make that decision it keeps a bounded stack of return addresses. Each CALL pushes the address of the instruction that follows it. Each RET pops the entry at the current depth and compares it with the actual target.

A synchronization strobe empties the stack. After a sync point, a decoder rebuilds its own view of the call nesting from scratch. For that reason, no return may be compressed against a CALL that was retired before the latest sync point. The block holds state for a single logical processor. A core with several logical processors places one instance per thread.

Each RET produces a registered decision one cycle after the event. The decision has a valid strobe, a compressed flag and the destination IP. A packet formatter downstream turns it into either a single taken bit or a target packet.

Top module: `ret_comp_tracker`

## Requirements
- R1: After reset, `dec_valid` and `dec_compressed` are low and the stack is empty, so the first RET is reported uncompressed.
- R2: A RET whose target equals the next-sequential IP of the most recent unmatched CALL gives `dec_compressed`=1 together with `dec_valid`=1.
- R3: A RET whose target differs from the top entry is reported uncompressed. It still pops that entry, so a following RET is compared against the next older entry.
- R4: A RET that arrives while the stack is empty is reported uncompressed.
- R5: A sync strobe discards every entry, so RETs that follow it are uncompressed until new CALLs arrive.
- R6: When a CALL and a sync strobe occur in the same cycle, the sync is applied first and that CALL becomes the only valid entry.
- R7: When a RET and a sync strobe occur in the same cycle, the sync is applied first, so that RET is uncompressed.
- R8: The stack holds DEPTH entries (default 16). A CALL that arrives while the stack is full discards the oldest entry, and the depth stays at DEPTH.
- R9: `dec_valid` is high for exactly one cycle, one clock after each RET, and never after a CALL, an idle cycle or a reserved kind. Kind encoding on `ev_kind`: 2'b00 idle, 2'b01 CALL, 2'b10 RET, 2'b11 reserved (treated as idle).
- R10: With every decision, `dec_target` carries the RET's target IP, whether the RET is compressed or not.
- R11: Nested CALLs are matched in last-in first-out order: RETs in reverse order of their CALLs are all compressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_kind | input | 2 | Retired event kind: 00 idle, 01 CALL, 10 RET, 11 reserved |
| ev_next_ip | input | IPW | Address of the instruction after the CALL (used for CALL) |
| ev_target_ip | input | IPW | Actual destination of the RET (used for RET) |
| sync_strobe | input | 1 | Synchronization packet emitted this cycle; empties the stack |
| dec_valid | output | 1 | Decision for the RET of the previous cycle is present |
| dec_compressed | output | 1 | 1: emit a single taken bit; 0: emit a target packet |
| dec_target | output | IPW | Destination IP of that RET |

## Verification
The assertions assume that `ev_kind` and `sync_strobe` are known, never X, in every cycle after reset. They also assume that the IP buses carry meaningful values only for the event kind that uses them. The bench drives every input on the falling edge and always holds a defined kind: idle cycles use 00, and a few cycles use the reserved code 11. The bench keeps its own reference stack, which follows the requirements. It uses a small pool of addresses so that random RETs both hit and miss the top entry. It mixes sync strobes with CALLs and RETs in the same cycle.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {
    EV_IDLE = 2'b00,
    EV_CALL = 2'b01,
    EV_RET  = 2'b10,
    EV_RSVD = 2'b11
  } ev_kind_e;
endpackage

// File: rtl/rcs_stack.sv
// Circular return-address stack. When full, a push overwrites the oldest slot.
module rcs_stack #(
  parameter int IPW   = 48,
  parameter int DEPTH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           push,
  input  logic           pop,
  input  logic [IPW-1:0] push_addr,
  output logic [IPW-1:0] top_addr,
  output logic           empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int DW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [DW-1:0] FULL = DW'(DEPTH);

  logic [IPW-1:0] mem [DEPTH];
  logic [PW-1:0]  wr_ptr;
  logic [PW-1:0]  ptr_inc, ptr_dec;
  logic [DW-1:0]  depth;
  logic           full;

  assign ptr_inc  = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  assign ptr_dec  = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
  assign full     = (depth == FULL);
  assign empty    = (depth == '0);
  assign top_addr = mem[ptr_dec];

  // Storage has no reset, so it can map onto distributed RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      depth  <= '0;
    end else begin
      if (push)      wr_ptr <= ptr_inc;
      else if (pop)  wr_ptr <= ptr_dec;

      if (clear)                depth <= push ? DW'(1) : '0;
      else if (push && !full)   depth <= depth + 1'b1;
      else if (pop && !empty)   depth <= depth - 1'b1;
    end
  end

  a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
    depth <= FULL);
  a_r8_full_saturates: assert property (@(posedge clk) disable iff (rst)
    (!clear && push && full) |=> full);
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (rst)
    (clear && !push) |=> empty);
  a_r6_clear_push_single: assert property (@(posedge clk) disable iff (rst)
    (clear && push) |=> (depth == DW'(1)));
  a_r11_push_then_top: assert property (@(posedge clk) disable iff (rst)
    push |=> (top_addr == $past(push_addr)));
endmodule

// File: rtl/rcs_decide.sv
// Compares the RET target with the stack top and registers the decision.
module rcs_decide #(
  parameter int IPW = 48
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           is_ret,
  input  logic           sync,
  input  logic           stk_empty,
  input  logic [IPW-1:0] stk_top,
  input  logic [IPW-1:0] target,
  output logic           dec_valid,
  output logic           dec_compressed,
  output logic [IPW-1:0] dec_target
);
  logic hit;
  assign hit = is_ret && !sync && !stk_empty && (stk_top == target);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid      <= 1'b0;
      dec_compressed <= 1'b0;
      dec_target     <= '0;
    end else begin
      dec_valid      <= is_ret;
      dec_compressed <= hit;
      if (is_ret) dec_target <= target;
    end
  end

  a_r9_valid_after_ret: assert property (@(posedge clk) disable iff (rst)
    is_ret |=> dec_valid);
  a_r9_quiet_otherwise: assert property (@(posedge clk) disable iff (rst)
    !is_ret |=> !dec_valid);
  a_r2_compress_implies_valid: assert property (@(posedge clk) disable iff (rst)
    dec_compressed |-> dec_valid);
  a_r7_sync_ret_plain: assert property (@(posedge clk) disable iff (rst)
    (is_ret && sync) |=> !dec_compressed);
  a_r4_empty_ret_plain: assert property (@(posedge clk) disable iff (rst)
    (is_ret && stk_empty) |=> !dec_compressed);
  a_r10_target_carried: assert property (@(posedge clk) disable iff (rst)
    is_ret |=> (dec_target == $past(target)));
endmodule

// File: rtl/ret_comp_tracker.sv
module ret_comp_tracker #(
  parameter int IPW   = 48,
  parameter int DEPTH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     ev_kind,
  input  logic [IPW-1:0] ev_next_ip,
  input  logic [IPW-1:0] ev_target_ip,
  input  logic           sync_strobe,
  output logic           dec_valid,
  output logic           dec_compressed,
  output logic [IPW-1:0] dec_target
);
  import rcs_pkg::*;

  ev_kind_e       kind;
  logic           is_call, is_ret, do_pop;
  logic           stk_empty;
  logic [IPW-1:0] stk_top;

  assign kind    = ev_kind_e'(ev_kind);
  assign is_call = (kind == EV_CALL);
  assign is_ret  = (kind == EV_RET);
  // Sync is applied first: a RET in a sync cycle meets an empty stack.
  assign do_pop  = is_ret && !sync_strobe && !stk_empty;

  rcs_stack #(.IPW(IPW), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .clear     (sync_strobe),
    .push      (is_call),
    .pop       (do_pop),
    .push_addr (ev_next_ip),
    .top_addr  (stk_top),
    .empty     (stk_empty)
  );

  rcs_decide #(.IPW(IPW)) u_decide (
    .clk            (clk),
    .rst            (rst),
    .is_ret         (is_ret),
    .sync           (sync_strobe),
    .stk_empty      (stk_empty),
    .stk_top        (stk_top),
    .target         (ev_target_ip),
    .dec_valid      (dec_valid),
    .dec_compressed (dec_compressed),
    .dec_target     (dec_target)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!dec_valid && !dec_compressed));
  a_r5_sync_blocks_next_ret: assert property (@(posedge clk) disable iff (rst)
    (sync_strobe && !is_call) |=> (is_ret |=> !dec_compressed));
endmodule

// File: tb/ret_comp_tracker_tb.sv
module ret_comp_tracker_tb;
  localparam int IPW   = 48;
  localparam int DEPTH = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     ev_kind = 2'b00;
  logic [IPW-1:0] ev_next_ip = '0;
  logic [IPW-1:0] ev_target_ip = '0;
  logic           sync_strobe = 1'b0;
  logic           dec_valid, dec_compressed;
  logic [IPW-1:0] dec_target;

  always #2.5 clk = ~clk;

  ret_comp_tracker #(.IPW(IPW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .ev_kind(ev_kind), .ev_next_ip(ev_next_ip),
    .ev_target_ip(ev_target_ip), .sync_strobe(sync_strobe),
    .dec_valid(dec_valid), .dec_compressed(dec_compressed), .dec_target(dec_target)
  );

  typedef struct {
    logic           v;
    logic           c;
    logic [IPW-1:0] t;
    string          tag;
  } exp_t;

  exp_t           sb[$];
  logic [IPW-1:0] model[$];
  int             n_chk = 0;
  int             n_bad = 0;
  logic           mon_on = 1'b0;
  logic           done = 1'b0;

  // Drives one event; the reference stack follows the requirements.
  task automatic drive(input logic [1:0] k, input logic [IPW-1:0] nip,
                       input logic [IPW-1:0] tgt, input logic s, input string tag);
    exp_t e;
    @(negedge clk);
    ev_kind = k; ev_next_ip = nip; ev_target_ip = tgt; sync_strobe = s;
    if (s) model.delete();
    e.v = 1'b0; e.c = 1'b0; e.t = '0; e.tag = tag;
    if (k == 2'b01) begin
      model.push_back(nip);
      if (model.size() > DEPTH) void'(model.pop_front());
    end else if (k == 2'b10) begin
      e.v = 1'b1; e.t = tgt;
      if (model.size() > 0) begin
        e.c = (model[model.size()-1] == tgt);
        void'(model.pop_back());
      end
    end
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(2'b00, '0, '0, 1'b0, "R9");
  endtask

  // Monitor: sample 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      exp_t e;
      if (sb.size() > 0) e = sb.pop_front();
      else begin e.v = 1'b0; e.c = 1'b0; e.t = '0; e.tag = "R9"; end
      n_chk++;
      if (dec_valid !== e.v ||
          (e.v && (dec_compressed !== e.c || dec_target !== e.t))) begin
        n_bad++;
        $display("FAIL %s: valid=%b comp=%b tgt=%h expected valid=%b comp=%b tgt=%h",
                 e.tag, dec_valid, dec_compressed, dec_target, e.v, e.c, e.t);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (dec_valid !== 1'b0 || dec_compressed !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: valid=%b comp=%b expected valid=0 comp=0", dec_valid, dec_compressed);
    end
    @(negedge clk); rst = 1'b0;
    @(posedge clk); mon_on = 1'b1;

    // R1: first RET after reset meets an empty stack
    drive(2'b10, '0, 48'h1234, 1'b0, "R1");
    // R9: CALL, reserved kind and idle give no decision
    drive(2'b01, 48'h100, '0, 1'b0, "R9");
    drive(2'b11, 48'h999, 48'h999, 1'b0, "R9");
    idle(2);
    // R2: matching return
    drive(2'b10, '0, 48'h100, 1'b0, "R2");
    // R11: nested LIFO
    drive(2'b01, 48'h200, '0, 1'b0, "R11");
    drive(2'b01, 48'h300, '0, 1'b0, "R11");
    drive(2'b01, 48'h400, '0, 1'b0, "R11");
    drive(2'b10, '0, 48'h400, 1'b0, "R11");
    drive(2'b10, '0, 48'h300, 1'b0, "R11");
    drive(2'b10, '0, 48'h200, 1'b0, "R11");
    // R3: mismatch pops, next RET sees older entry
    drive(2'b01, 48'hA00, '0, 1'b0, "R3");
    drive(2'b01, 48'hB00, '0, 1'b0, "R3");
    drive(2'b10, '0, 48'hC00, 1'b0, "R3");
    drive(2'b10, '0, 48'hA00, 1'b0, "R3");
    // R4: empty stack
    drive(2'b10, '0, 48'hA00, 1'b0, "R4");
    // R5: sync alone empties stack
    drive(2'b01, 48'h510, '0, 1'b0, "R5");
    drive(2'b01, 48'h520, '0, 1'b0, "R5");
    drive(2'b00, '0, '0, 1'b1, "R5");
    drive(2'b10, '0, 48'h520, 1'b0, "R5");
    drive(2'b10, '0, 48'h510, 1'b0, "R5");
    // R6: sync with CALL keeps only that CALL
    drive(2'b01, 48'h610, '0, 1'b0, "R6");
    drive(2'b01, 48'h620, '0, 1'b1, "R6");
    drive(2'b10, '0, 48'h620, 1'b0, "R6");
    drive(2'b10, '0, 48'h610, 1'b0, "R6");
    // R7: sync with RET
    drive(2'b01, 48'h710, '0, 1'b0, "R7");
    drive(2'b10, '0, 48'h710, 1'b1, "R7");
    drive(2'b10, '0, 48'h710, 1'b0, "R7");
    // R8: overflow drops oldest
    for (int i = 0; i <= DEPTH; i++) drive(2'b01, 48'h8000 + IPW'(i), '0, 1'b0, "R8");
    for (int i = DEPTH; i >= 0; i--) drive(2'b10, '0, 48'h8000 + IPW'(i), 1'b0, "R8");
    // R10: target carried on random mix, plus all rules again
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 9);
      logic [IPW-1:0] a = 48'hF000 + IPW'($urandom_range(0, 3));
      logic s = ($urandom_range(0, 15) == 0);
      if (r < 4)       drive(2'b01, a, '0, s, "R10");
      else if (r < 8)  drive(2'b10, '0, a, s, "R10");
      else if (r == 8) drive(2'b11, a, a, s, "R10");
      else             drive(2'b00, '0, '0, s, "R10");
    end
    idle(3);
    @(negedge clk);
    done = 1'b1;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R9: %0d decisions outstanding, expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule